// File: doc/BRIEF.md
# Strap-Addressed SMBus Register Slave

This block is a two-wire SMBus target. It lets an external management agent read and write any location of an internal configuration register bank. The bus address the block answers to is partly fixed and partly taken from four strap pins. The straps are sampled while reset is held and frozen when reset is released, so board-level strapping selects the address and later pin activity has no effect.

A write transfer carries the device address with the write direction, a register offset and one data byte. The block acknowledges each of those bytes and issues a single write strobe to the bank. A read transfer sets the offset the same way, then uses a repeated START and the device address with the read direction. The block then shifts out the addressed register's contents. Both bus lines pass through a two-flop synchroniser before any edge or START/STOP detection, and the block drives SDA low only while SCL is low.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The strap inputs are captured on every clock edge while `rst` is high, and the value present at the last such edge is held. Strap changes after reset has been released do not change the device address.
- R2: The 7-bit device address, MSB first, is {1, 1, strap_i[3], 0, strap_i[2], strap_i[1], strap_i[0]}. It is compared against bits 7:1 of the first byte after a START. Bit 0 of that byte selects the direction: 0 is write, 1 is read.
- R3: The write sequence is address (write), offset, data. The slave acknowledges each of these bytes by holding SDA low during the ninth SCL pulse. It raises `reg_wr` for exactly one clock, with `reg_addr` equal to the offset and `reg_wdata` equal to the data. Any byte after the data byte is not acknowledged and causes no write.
- R4: The read sequence is address (write), offset, repeated START, address (read). After it, the slave acknowledges and shifts out the bank value at the offset, MSB first, one bit per SCL pulse. After the master's acknowledge bit the slave leaves SDA released until the next START.
- R5: An address byte that does not match is not acknowledged. The slave then neither acknowledges nor writes anything until the next START.
- R6: A STOP returns the slave to idle, and bytes clocked afterwards without a START are ignored. A START seen in any state restarts address reception.
- R7: `sda_oe` changes only while SCL is low, never during an SCL high phase that contains no START or STOP.
- R8: The acknowledge drive appears on the third rising `clk` edge after the SCL pin falls at the end of the eighth bit.
- R9: During and right after reset, `sda_oe` and `reg_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_i | input | 1 | SMBus clock line as seen at the pin |
| sda_i | input | 1 | SMBus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the SDA line low (open drain) |
| strap_i | input | 4 | Address strap pins |
| reg_addr | output | REG_AW (8) | Register offset presented to the bank |
| reg_wr | output | 1 | One-cycle write strobe to the bank |
| reg_wdata | output | 8 | Write data to the bank |
| reg_rdata | input | 8 | Bank read data for `reg_addr`, combinational |

## Verification
Every bus event reaches the control logic three rising `clk` edges after the pin changes: two synchroniser flops, then the state register. The acknowledge drive, each read data bit and the write strobe all become visible in the cycle after that third edge. The bench asserts that exact delay for the acknowledge by sampling `sda_oe` on each of the three falling `clk` edges that follow the final SCL fall of every byte. For all other results, the bench holds each SCL phase for six clocks and samples SDA in the middle of the high phase, well after the three-edge delay has elapsed. A per-clock monitor compares every `reg_wr` strobe, in the cycle it occurs, against a queue of expected writes built from the transfers the bench issues.

// File: rtl/smbslv_pkg.sv
package smbslv_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int STRAP_W = 4;
    localparam int DEV_AW  = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_AW,
        ST_ACK_AR,
        ST_OFFS,
        ST_ACK_OF,
        ST_WDATA,
        ST_ACK_WD,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } slv_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // fixed bits 6,5 = 1, bit 3 = 0; straps fill the rest
    function automatic logic [DEV_AW-1:0] build_addr(input logic [STRAP_W-1:0] s);
        return {2'b11, s[3], 1'b0, s[2:0]};
    endfunction

    function automatic logic is_ack_state(input slv_state_e s);
        return (s == ST_ACK_AW) || (s == ST_ACK_AR) ||
               (s == ST_ACK_OF) || (s == ST_ACK_WD);
    endfunction

endpackage

// File: rtl/smbslv_sync.sv
module smbslv_sync
    import smbslv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int LINES = 2;

    logic [LINES-1:0] pins;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] last;
    logic [1:0]       age;

    assign pins = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk) begin
            if (rst) ff <= '1;
            else     ff <= {ff[STAGES-2:0], pins[g]};
        end
        assign cur[g] = ff[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last <= '1;
            age  <= '0;
        end else begin
            last <= cur;
            if (age != 2'd3) age <= age + 2'd1;
        end
    end

    assign evt.scl      = cur[1];
    assign evt.sda      = cur[0];
    assign evt.scl_rise = cur[1] & ~last[1];
    assign evt.scl_fall = ~cur[1] & last[1];
    assign evt.start    = cur[1] & last[1] & last[0] & ~cur[0];
    assign evt.stop     = cur[1] & last[1] & ~last[0] & cur[0];

    // R8
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && evt.scl_rise) |-> ($past(scl_i, 2) && !$past(scl_i, 3)));

endmodule

// File: rtl/smbslv_strap.sv
module smbslv_strap
    import smbslv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [DEV_AW-1:0]  dev_addr
);
    logic [STRAP_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) held <= strap_i;
    end

    assign dev_addr = build_addr(held);

endmodule

// File: rtl/smbslv_engine.sv
module smbslv_engine
    import smbslv_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [DEV_AW-1:0] dev_addr,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata
);
    slv_state_e        state, st_n;
    logic [BYTE_W-1:0] shift, sh_n;
    logic [CNT_W-1:0]  bitcnt, cnt_n;
    logic [BYTE_W-1:0] offs, offs_n;
    logic [BYTE_W-1:0] wdata_q, wd_n;
    logic              wr_q, wr_n;
    logic              byte_done;

    assign byte_done = (bitcnt == CNT_W'(BYTE_W));

    always_comb begin
        st_n   = state;
        sh_n   = shift;
        cnt_n  = bitcnt;
        offs_n = offs;
        wd_n   = wdata_q;
        wr_n   = 1'b0;
        if (evt.stop) begin
            st_n = ST_IDLE;
        end else if (evt.start) begin
            st_n  = ST_ADDR;
            cnt_n = '0;
        end else begin
            case (state)
                ST_ADDR, ST_OFFS, ST_WDATA: begin
                    if (evt.scl_rise && !byte_done) begin
                        sh_n  = {shift[BYTE_W-2:0], evt.sda};
                        cnt_n = bitcnt + CNT_W'(1);
                    end else if (evt.scl_fall && byte_done) begin
                        cnt_n = '0;
                        if (state == ST_ADDR) begin
                            if (shift[BYTE_W-1:1] == dev_addr)
                                st_n = shift[0] ? ST_ACK_AR : ST_ACK_AW;
                            else
                                st_n = ST_IGNORE;
                        end else if (state == ST_OFFS) begin
                            offs_n = shift;
                            st_n   = ST_ACK_OF;
                        end else begin
                            wr_n = 1'b1;
                            wd_n = shift;
                            st_n = ST_ACK_WD;
                        end
                    end
                end
                ST_ACK_AW: if (evt.scl_fall) st_n = ST_OFFS;
                ST_ACK_OF: if (evt.scl_fall) st_n = ST_WDATA;
                ST_ACK_WD: if (evt.scl_fall) st_n = ST_IGNORE;
                ST_ACK_AR: begin
                    if (evt.scl_fall) begin
                        st_n  = ST_RDATA;
                        sh_n  = reg_rdata;
                        cnt_n = '0;
                    end
                end
                ST_RDATA: begin
                    if (evt.scl_rise && !byte_done) begin
                        cnt_n = bitcnt + CNT_W'(1);
                    end else if (evt.scl_fall) begin
                        if (byte_done) st_n = ST_RACK;
                        else           sh_n = {shift[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_RACK: if (evt.scl_fall) st_n = ST_IGNORE;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shift   <= '0;
            bitcnt  <= '0;
            offs    <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else begin
            state   <= st_n;
            shift   <= sh_n;
            bitcnt  <= cnt_n;
            offs    <= offs_n;
            wdata_q <= wd_n;
            wr_q    <= wr_n;
        end
    end

    assign sda_oe    = is_ack_state(state) || (state == ST_RDATA && !shift[BYTE_W-1]);
    assign reg_addr  = offs[REG_AW-1:0];
    assign reg_wr    = wr_q;
    assign reg_wdata = wdata_q;

    // R5
    mismatch_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && !evt.start && !evt.stop && evt.scl_fall && byte_done &&
         shift[BYTE_W-1:1] != dev_addr) |=> !sda_oe);

    // R7
    sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.scl && !evt.start && !evt.stop) |=> $stable(sda_oe));

    // R3
    write_ack_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (state == ST_ACK_WD && sda_oe));

    // R6
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE && !sda_oe));

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
    import smbslv_pkg::*;
#(
    parameter int REG_AW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [3:0]        strap_i,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_wr,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata
);
    bus_evt_t          evt;
    logic [DEV_AW-1:0] dev_addr;

    smbslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    smbslv_strap u_strap (
        .clk      (clk),
        .rst      (rst),
        .strap_i  (strap_i),
        .dev_addr (dev_addr)
    );

    smbslv_engine #(.REG_AW(REG_AW)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .dev_addr  (dev_addr),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata)
    );

endmodule

// File: tb/sim_smbus_cfg_slave.sv
module sim_smbus_cfg_slave;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic       scl;
    logic       sda_m;
    logic [3:0] strap;
    logic       sda_oe;
    logic       sda_line;
    logic       reg_wr;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] bank [256];
    logic [15:0] exp_wr [$];
    int checks = 0;
    int errors = 0;
    logic oe_prev;
    logic scl_prev;
    int r7_viol = 0;

    always #5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    smbus_cfg_slave u0 (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap_i   (strap),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock reference comparison: write strobes and SDA drive timing
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R3 unexpected write", {reg_addr, reg_wdata}, 0);
                end else begin
                    chk({reg_addr, reg_wdata} == exp_wr[0], "R3 write strobe",
                        {reg_addr, reg_wdata}, exp_wr[0]);
                    void'(exp_wr.pop_front());
                end
            end
            if (scl && scl_prev && sda_oe != oe_prev) r7_viol++;
        end
        oe_prev  = sda_oe;
        scl_prev = scl;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1;
        wait_clk(2);
        scl = 1'b1;
        wait_clk(HALF);
        sda_m = 1'b0;
        wait_clk(HALF);
        scl = 1'b0;
        wait_clk(2);
    endtask

    task automatic do_stop();
        scl = 1'b0;
        sda_m = 1'b0;
        wait_clk(HALF);
        scl = 1'b1;
        wait_clk(HALF);
        sda_m = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;
        wait_clk(HALF);
        scl = 1'b1;
        wait_clk(HALF);
        scl = 1'b0;
        wait_clk(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic [2:0] lat);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            wait_clk(HALF);
            scl = 1'b1;
            wait_clk(HALF);
            scl = 1'b0;
            if (i > 0) wait_clk(2);
        end
        for (int k = 0; k < 3; k++) begin
            wait_clk(1);
            lat[k] = sda_oe;
        end
        sda_m = 1'b1;
        wait_clk(HALF);
        scl = 1'b1;
        wait_clk(HALF / 2);
        ack = !sda_line;
        wait_clk(HALF / 2);
        scl = 1'b0;
        wait_clk(2);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic master_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(HALF);
            scl = 1'b1;
            wait_clk(HALF / 2);
            v[i] = sda_line;
            wait_clk(HALF / 2);
            scl = 1'b0;
            wait_clk(2);
        end
        send_bit(!master_ack);
    endtask

    task automatic write_txn(input logic [6:0] dev, input logic [7:0] offs, input logic [7:0] data,
                             input bit expect_ok, input string req);
        logic a;
        logic [2:0] l;
        do_start();
        send_byte({dev, 1'b0}, a, l);
        chk(a == expect_ok, {req, " address ack"}, a, expect_ok);
        send_byte(offs, a, l);
        chk(a == expect_ok, {req, " offset ack"}, a, expect_ok);
        if (expect_ok) begin
            exp_wr.push_back({offs, data});
            bank[offs] = data;
        end
        send_byte(data, a, l);
        chk(a == expect_ok, {req, " data ack"}, a, expect_ok);
        do_stop();
        wait_clk(4);
    endtask

    task automatic read_txn(input logic [6:0] dev, input logic [7:0] offs, input logic [7:0] expv,
                            input string req);
        logic a;
        logic [2:0] l;
        logic [7:0] v;
        do_start();
        send_byte({dev, 1'b0}, a, l);
        chk(a, {req, " address ack"}, a, 1);
        send_byte(offs, a, l);
        chk(a, {req, " offset ack"}, a, 1);
        do_start();
        send_byte({dev, 1'b1}, a, l);
        chk(a, {req, " read address ack"}, a, 1);
        recv_byte(v, 1'b0);
        chk(v == expv, {req, " read data"}, v, expv);
        wait_clk(4);
        chk(sda_oe == 1'b0, {req, " released after nack"}, sda_oe, 0);
        do_stop();
        wait_clk(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        logic [2:0] l;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) bank[i] = 8'(i * 7 + 3);
        rst = 1'b1;
        scl = 1'b1;
        sda_m = 1'b1;
        strap = 4'b0000;
        wait_clk(3);
        strap = 4'b1011;
        wait_clk(3);
        // R9 reset state
        chk(sda_oe == 1'b0 && reg_wr == 1'b0, "R9 reset outputs", {sda_oe, reg_wr}, 0);
        rst = 1'b0;
        wait_clk(1);
        strap = 4'b0100;   // R1: must be ignored now
        wait_clk(4);
        chk(sda_oe == 1'b0 && reg_wr == 1'b0, "R9 after release", {sda_oe, reg_wr}, 0);

        // R8 ack latency and R1/R2 address 0x73
        do_start();
        send_byte({7'h73, 1'b0}, a, l);
        chk(l == 3'b100, "R8 ack on third edge", l, 3'b100);
        chk(a, "R1 latched straps ack", a, 1);
        send_byte(8'h15, a, l);
        chk(a, "R3 offset ack", a, 1);
        exp_wr.push_back({8'h15, 8'hA5});
        bank[8'h15] = 8'hA5;
        send_byte(8'hA5, a, l);
        chk(a, "R3 data ack", a, 1);
        // R3 extra byte not acked, no write
        send_byte(8'h99, a, l);
        chk(!a && l == 3'b000, "R3 extra byte nack", a, 0);
        do_stop();
        wait_clk(4);

        // R1 straps changed after reset give 0x64, which must be ignored
        write_txn(7'h64, 8'h40, 8'h11, 1'b0, "R1 post-reset strap");
        // R2 single-bit differences from 0x73
        for (int k = 0; k < 7; k++) begin
            do_start();
            send_byte({7'h73 ^ 7'(1 << k), 1'b0}, a, l);
            chk(!a, "R2 address bit mismatch", a, 0);
            // R5 following byte not acknowledged either
            send_byte(8'h15, a, l);
            chk(!a, "R5 ignored after mismatch", a, 0);
            do_stop();
            wait_clk(4);
        end

        // R4 reads
        read_txn(7'h73, 8'h15, 8'hA5, "R4 readback");
        bank[8'h3C] = 8'h5A;
        read_txn(7'h73, 8'h3C, 8'h5A, "R4 read 3C");
        bank[8'hFF] = 8'h81;
        read_txn(7'h73, 8'hFF, 8'h81, "R4 read FF");
        write_txn(7'h73, 8'h00, 8'hFF, 1'b1, "R3 write 00");
        read_txn(7'h73, 8'h00, 8'hFF, "R4 read 00");

        // R6 stop returns to idle
        do_start();
        send_byte({7'h73, 1'b0}, a, l);
        chk(a, "R6 address before stop", a, 1);
        do_stop();
        wait_clk(4);
        scl = 1'b0;
        wait_clk(2);
        send_byte(8'h15, a, l);
        chk(!a, "R6 byte after stop ignored", a, 0);
        scl = 1'b1;
        sda_m = 1'b1;
        wait_clk(HALF);
        // R6 start mid-byte restarts reception
        do_start();
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        write_txn(7'h73, 8'h20, 8'h3E, 1'b1, "R6 restart");
        read_txn(7'h73, 8'h20, 8'h3E, "R6 restart read");

        // R1/R2 new reset with other straps
        rst = 1'b1;
        strap = 4'b0100;
        wait_clk(4);
        chk(sda_oe == 1'b0 && reg_wr == 1'b0, "R9 second reset", {sda_oe, reg_wr}, 0);
        rst = 1'b0;
        wait_clk(4);
        write_txn(7'h64, 8'h41, 8'h6C, 1'b1, "R2 strap 0100");
        write_txn(7'h73, 8'h42, 8'h01, 1'b0, "R1 old address");
        read_txn(7'h64, 8'h41, 8'h6C, "R4 new address read");

        wait_clk(10);
        chk(exp_wr.size() == 0, "R3 all writes seen", exp_wr.size(), 0);
        chk(r7_viol == 0, "R7 SDA drive stable while SCL high", r7_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule